// File: doc/BRIEF.md
# Twisted-Ring Staircase Sine Generator

This block produces a stepped approximation of a sinewave from a single logic edge that circulates through a twisted-ring (Johnson) shift register. Each register output carries a fixed signed weight derived from a cosine. The weight is added when the output is 1 and subtracted when it is 0. The resulting staircase has one new level per advance and repeats every `2*STAGES` advances. With the default of eight stages, the fundamental is the advance rate divided by 16. The lowest remaining harmonic is then the 15th, roughly 24 dB under the fundamental.

The clock enable sets the rate: each enabled clock edge is one step of the staircase. The raw ring outputs and the registered signed sample are both brought out, so a resistor network can use the taps directly, or a DAC can take the sample word. Raising `STAGES` gives a longer ring with matching weights, which produces finer steps and pushes the first harmonic further up. The block has no amplitude control loop. The first period after reset, and after any change in enable rate, is already at full amplitude.

Top module: `stair_sine_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next tap vector is all zeros and the sample becomes `-PEAK`. This holds whatever `en` is. `PEAK` is the sum of all weights.
- R2: On each edge with `en` high and a legal ring, the taps shift one place toward the most significant bit, and bit 0 takes the inverse of the old top bit. The tap pattern therefore repeats every `2*STAGES` enabled edges.
- R3: On an edge with `en` low, neither the taps nor the sample change.
- R4: Weight k (0 ≤ k < STAGES) is round(AMPLITUDE/2 · (cos(πk/STAGES) − cos(π(k+1)/STAGES))). After every edge, the sample equals the sum over k of +weight k where tap k is 1 and −weight k where tap k is 0.
- R5: Half-wave antisymmetry: the sample `STAGES` enabled edges later is the exact negative of the current sample.
- R6: A ring is legal when at most one pair of adjacent taps differs. An illegal ring is replaced by all zeros on the next enabled edge, and the sample then becomes `-PEAK`.
- R7: Starting from reset, the sample reaches `+PEAK` after exactly `STAGES` enabled edges and returns to `-PEAK` after `2*STAGES`. There is no build-up of amplitude.
- R8: Within a period, the sample rises strictly on each enabled edge taken from a state whose top tap is 0. It falls strictly on each enabled edge taken from a state whose top tap is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; one staircase step per enabled edge |
| taps | output | STAGES | Twisted-ring register outputs |
| sample | output | SAMPLE_W | Signed staircase sample, registered |

## Verification
The taps and the sample are both registered, so the result of an enabled edge is visible directly after that edge. A reset or an illegal-state correction also takes effect on the same edge that applies it. The bench changes `en` and `rst` on the falling clock edge. Its behavioural phase counter then advances for the rising edge that follows, and both outputs are compared on the next falling edge, one full cycle after the stimulus. Antisymmetry, monotonic direction and peak timing are checked from the per-phase samples that this lock-step comparison records.

// File: rtl/stair_sine_gen.sv
module stair_sine_gen #(
  parameter int STAGES    = 8,
  parameter int SAMPLE_W  = 16,
  parameter int AMPLITUDE = 30000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  output logic [STAGES-1:0]          taps,
  output logic signed [SAMPLE_W-1:0] sample
);

  localparam real PI = 3.14159265358979;

  function automatic int weight(input int k);
    real lo, hi;
    lo = $cos(PI * k / STAGES);
    hi = $cos(PI * (k + 1) / STAGES);
    return int'((AMPLITUDE / 2.0) * (lo - hi));
  endfunction

  function automatic int peak_sum();
    int s;
    s = 0;
    for (int k = 0; k < STAGES; k++) s += weight(k);
    return s;
  endfunction

  localparam int PEAK = peak_sum();

  logic [STAGES-1:0]          ring_q, ring_d;
  logic [STAGES-2:0]          edges;
  logic                       ring_ok;
  logic signed [SAMPLE_W-1:0] term [STAGES];
  logic signed [SAMPLE_W-1:0] sum_d;

  assign edges   = ring_q[STAGES-1:1] ^ ring_q[STAGES-2:0];
  assign ring_ok = (edges & (edges - 1'b1)) == '0;
  assign ring_d  = ring_ok ? {ring_q[STAGES-2:0], ~ring_q[STAGES-1]} : '0;

  for (genvar k = 0; k < STAGES; k++) begin : g_weight
    localparam int WK = weight(k);
    assign term[k] = ring_d[k] ? SAMPLE_W'(WK) : SAMPLE_W'(-WK);
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < STAGES; k++) sum_d = sum_d + term[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '0;
      sample <= SAMPLE_W'(-PEAK);
    end else if (en) begin
      ring_q <= ring_d;
      sample <= sum_d;
    end
  end

  assign taps = ring_q;

  a_r1_reset_ring: assert property (@(posedge clk)
    rst |=> (taps == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !en) |=> $stable(sample));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && ring_ok) |=> ($countones(taps ^ $past(taps)) == 1));

  a_r6_legal_after_step: assert property (@(posedge clk) disable iff (rst)
    (!rst && en) |=> ring_ok);

  a_r8_rising_half: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && ring_ok && !taps[STAGES-1]) |=> (sample > $past(sample)));

  a_r8_falling_half: assert property (@(posedge clk) disable iff (rst)
    (!rst && en && ring_ok && taps[STAGES-1]) |=> (sample < $past(sample)));

endmodule

// File: tb/stair_sine_gen_tb.sv
module stair_sine_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int SW  = 16;
  localparam int AMP = 30000;
  localparam int P   = 2 * N;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [N-1:0]          taps;
  logic signed [SW-1:0]  sample;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  int w [N];
  int peak;
  int exp_s [P];
  logic [N-1:0] exp_t [P];
  int seen [P];
  bit seen_ok [P];
  int phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  stair_sine_gen #(.STAGES(N), .SAMPLE_W(SW), .AMPLITUDE(AMP)) dut_i (
    .clk(clk), .rst(rst), .en(en), .taps(taps), .sample(sample));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit e, input string req);
    rst = r;
    en  = e;
    @(negedge clk);
    if (r) phase = 0;
    else if (e) phase = (phase + 1) % P;
    chk(taps == exp_t[phase], {req, " taps"}, int'(taps), int'(exp_t[phase]));
    chk(sample == SW'(exp_s[phase]), {req, " sample"}, int'(sample), exp_s[phase]);
    if (!r) begin
      seen[phase]    = int'(sample);
      seen_ok[phase] = 1'b1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    peak = 0;
    for (int k = 0; k < N; k++) begin
      w[k] = int'((AMP / 2.0) * ($cos(PI * k / N) - $cos(PI * (k + 1) / N)));
      peak += w[k];
    end
    for (int t = 0; t <= N; t++) begin
      int acc;
      acc = -peak;
      for (int k = 0; k < t; k++) acc += 2 * w[k];
      exp_s[t % P] = acc;
      exp_t[t % P] = N'((1 << t) - 1);
    end
    for (int t = N + 1; t < P; t++) begin
      exp_s[t] = -exp_s[t - N];
      exp_t[t] = ~N'((1 << (t - N)) - 1);
    end
    for (int t = 0; t < P; t++) seen_ok[t] = 1'b0;
    phase = 0;

    // R1: reset state, also with enable high during reset
    repeat (2) step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");

    // R2 R4 R7: continuous stepping from reset
    for (int i = 0; i < P + 3; i++) begin
      step(1'b0, 1'b1, "R2/R4");
      if (i == N - 1)
        chk(sample == SW'(peak), "R7 peak after STAGES steps", int'(sample), peak);
      if (i == P - 1)
        chk(sample == SW'(-peak), "R7 trough after 2*STAGES steps", int'(sample), -peak);
    end

    // R3: irregular enable pattern including long stalls
    for (int i = 0; i < 300; i++)
      step(1'b0, (($urandom % 3) != 0), "R3/R4");
    repeat (5) step(1'b0, 1'b0, "R3 stall");

    // R6: forced illegal states are cleared on the next enabled edge
    begin
      logic [N-1:0] bad [2];
      bad[0] = N'(8'h81);
      bad[1] = N'(8'h5A);
      for (int j = 0; j < 2; j++) begin
        repeat (3) step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R3");
        force dut_i.ring_q = bad[j];
        #1;
        release dut_i.ring_q;
        rst = 1'b0;
        en  = 1'b1;
        @(negedge clk);
        phase = 0;
        chk(taps == '0, "R6 taps cleared", int'(taps), 0);
        chk(sample == SW'(-peak), "R6 sample after clear", int'(sample), -peak);
      end
      for (int i = 0; i < P; i++) step(1'b0, 1'b1, "R6 resume");
    end

    // R1: reset in mid-run
    repeat (5) step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R1 mid-run");
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, "R2 after reset");

    // R5 and R8 from recorded per-phase samples
    for (int t = 0; t < N; t++)
      chk(seen_ok[t] && seen_ok[t + N] && (seen[t + N] == -seen[t]),
          "R5 antisymmetry", seen[t + N], -seen[t]);
    for (int t = 0; t < P; t++) begin
      int nx;
      nx = (t + 1) % P;
      if (t < N) chk(seen[nx] > seen[t], "R8 rising", seen[nx], seen[t] + 1);
      else       chk(seen[nx] < seen[t], "R8 falling", seen[nx], seen[t] - 1);
    end

    finish_run();
  end
endmodule